// File: doc/BRIEF.md
# Digit-Serial GF(2^83) Multiply-Accumulate Unit

This block performs one fused multiply-accumulate in the binary field GF(2^83). The reduction polynomial is not fixed: every operation brings its own polynomial on an input port. Addition is bitwise XOR throughout, and no carries exist anywhere in the datapath. Two operations are offered. The plain form returns A·B + C mod P. The pre-add form first XORs D into B, then returns A·(B+D) + C mod P.

A host raises `start` for one cycle while the unit is idle. That cycle latches all operands and the operation select. The multiplier operand is then consumed twelve bits per clock, most-significant digit first, through an unrolled chain of shift-and-reduce stages. The operation always takes the same number of cycles, whatever the operand values. When it finishes, the result register updates and `done` pulses for one cycle. The result then holds until the next operation completes.

The controller is a four-state machine: IDLE → LOAD on an accepted start, LOAD → RUN unconditionally, RUN → RUN while digits remain, RUN → DONE on the last digit, DONE → IDLE unconditionally. In LOAD the multiplier register is filled with B or B⊕D and the accumulator is cleared. Each RUN cycle retires one digit. DONE presents the pulse.

Top module: `gfield_mac`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `result` is all zeros.
- R2: With `op_sel` = 0 at acceptance, the next result equals A·B + C reduced modulo P. Here `poly` bit i is the coefficient of x^i for i = 0..82, and the x^83 term is implied.
- R3: With `op_sel` = 1 at acceptance, the next result equals A·(B XOR D) + C reduced modulo P.
- R4: `done` goes high after the 8th rising edge following the edge that accepts `start`, and stays high for exactly one cycle.
- R5: `busy` is high from the edge that accepts `start` until `done` falls, and is low otherwise.
- R6: `start` has no effect while `busy` is high, including the cycle in which `done` is high. No extra operation and no extra `done` pulse result.
- R7: Operands and `op_sel` are sampled only on the accepting edge. Changing them afterwards does not alter the result.
- R8: `result` changes only on the edge that raises `done`, and holds its value between operations.
- R9: The result is correct for any 83-bit `poly` value and for boundary operands (zero, all ones).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request an operation; accepted only when idle |
| op_sel | input | 1 | 0: A·B+C, 1: A·(B+D)+C |
| opnd_a | input | 83 | Multiplicand A |
| opnd_b | input | 83 | Multiplier B |
| opnd_c | input | 83 | Addend C |
| opnd_d | input | 83 | Pre-add term D |
| poly | input | 83 | Reduction polynomial, low 83 coefficients |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 83 | Last completed result |

## Verification
Two events can fall in the same cycle: the completion pulse and a new start request. A new request can also arrive one cycle after the pulse. The bench holds `start` high, with junk operands, throughout a running operation and through its `done` cycle. It then checks that `busy` drops and that no extra completion shows up. It also issues the next operation in the first idle cycle after `done`, and checks that this operation is accepted with the correct latency. The scoreboard flags any `done` that arrives with no operation queued, and any result that differs from a bit-serial reference model.

// File: rtl/gfield_mac_pkg.sv
package gfield_mac_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2,
        ST_DONE = 2'd3
    } mac_state_t;
endpackage

// File: rtl/gfm_xtime.sv
// Multiply a field element by x and reduce with the supplied polynomial.
module gfm_xtime #(
    parameter int N = 83
) (
    input  logic [N-1:0] v_in,
    input  logic [N-1:0] poly,
    output logic [N-1:0] v_out
);
    always_comb begin
        v_out = {v_in[N-2:0], 1'b0} ^ (poly & {N{v_in[N-1]}});
    end
endmodule

// File: rtl/gfm_digit_step.sv
// One digit of Horner evaluation: acc*x^D + a*digit, reduced after each bit.
module gfm_digit_step #(
    parameter int N = 83,
    parameter int D = 12
) (
    input  logic [N-1:0] acc_in,
    input  logic [N-1:0] mcand,
    input  logic [N-1:0] poly,
    input  logic [D-1:0] digit,
    output logic [N-1:0] acc_out
);
    logic [N-1:0] chain   [0:D];
    logic [N-1:0] shifted [0:D-1];

    assign chain[0] = acc_in;

    for (genvar j = 0; j < D; j++) begin : g_stage
        gfm_xtime #(.N(N)) u_xt (
            .v_in  (chain[j]),
            .poly  (poly),
            .v_out (shifted[j])
        );
        assign chain[j+1] = shifted[j] ^ (mcand & {N{digit[D-1-j]}});
    end

    assign acc_out = chain[D];
endmodule

// File: rtl/gfm_ctrl.sv
// Sequencer: IDLE -> LOAD -> RUN (STEPS cycles) -> DONE -> IDLE.
module gfm_ctrl
    import gfield_mac_pkg::*;
#(
    parameter int STEPS = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic accept,
    output logic prep_en,
    output logic step_en,
    output logic last_step,
    output logic busy,
    output logic done
);
    localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [CW-1:0] LAST_CNT = CW'(STEPS - 1);

    mac_state_t state_q, state_d;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_LOAD)
                cnt_q <= '0;
            else if (state_q == ST_RUN)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_LOAD;
            ST_LOAD: state_d = ST_RUN;
            ST_RUN:  if (cnt_q == LAST_CNT) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        accept    = 1'b0;
        prep_en   = 1'b0;
        step_en   = 1'b0;
        last_step = 1'b0;
        busy      = 1'b1;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy   = 1'b0;
                accept = start;
            end
            ST_LOAD: prep_en = 1'b1;
            ST_RUN: begin
                step_en   = 1'b1;
                last_step = (cnt_q == LAST_CNT);
            end
            ST_DONE: done = 1'b1;
        endcase
    end
endmodule

// File: rtl/gfield_mac.sv
// GF(2^N) fused multiply-accumulate with programmable reduction polynomial.
module gfield_mac #(
    parameter int N = 83,
    parameter int D = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         op_sel,
    input  logic [N-1:0] opnd_a,
    input  logic [N-1:0] opnd_b,
    input  logic [N-1:0] opnd_c,
    input  logic [N-1:0] opnd_d,
    input  logic [N-1:0] poly,
    output logic         busy,
    output logic         done,
    output logic [N-1:0] result
);
    localparam int STEPS = (N + D - 1) / D;
    localparam int MW    = STEPS * D;

    logic accept, prep_en, step_en, last_step;

    logic [N-1:0]  a_q, b_q, c_q, d_q, p_q;
    logic          mode_q;
    logic [MW-1:0] mreg_q;
    logic [N-1:0]  acc_q, acc_next, res_q;
    logic [N-1:0]  mult_sel;

    gfm_ctrl #(.STEPS(STEPS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .accept    (accept),
        .prep_en   (prep_en),
        .step_en   (step_en),
        .last_step (last_step),
        .busy      (busy),
        .done      (done)
    );

    gfm_digit_step #(.N(N), .D(D)) u_step (
        .acc_in  (acc_q),
        .mcand   (a_q),
        .poly    (p_q),
        .digit   (mreg_q[MW-1 -: D]),
        .acc_out (acc_next)
    );

    assign mult_sel = mode_q ? (b_q ^ d_q) : b_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q    <= '0;
            b_q    <= '0;
            c_q    <= '0;
            d_q    <= '0;
            p_q    <= '0;
            mode_q <= 1'b0;
            mreg_q <= '0;
            acc_q  <= '0;
            res_q  <= '0;
        end else begin
            if (accept) begin
                a_q    <= opnd_a;
                b_q    <= opnd_b;
                c_q    <= opnd_c;
                d_q    <= opnd_d;
                p_q    <= poly;
                mode_q <= op_sel;
            end
            if (prep_en) begin
                mreg_q <= MW'(mult_sel);
                acc_q  <= '0;
            end
            if (step_en) begin
                acc_q  <= acc_next;
                mreg_q <= mreg_q << D;
            end
            if (last_step)
                res_q <= acc_next ^ c_q;
        end
    end

    assign result = res_q;
endmodule

// File: rtl/gfield_mac_chk.sv
module gfield_mac_chk #(
    parameter int N = 83,
    parameter int D = 12
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [N-1:0] result
);
    localparam int STEPS = (N + D - 1) / D;

    logic [7:0] lat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            lat_q <= '0;
        else if (start && !busy)
            lat_q <= 8'd1;
        else if (busy && lat_q != 8'hFF)
            lat_q <= lat_q + 8'd1;
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                           // R4
    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_q == 8'(STEPS + 2)));                        // R4
    AST_BUSY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);                                            // R5
    AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done));                     // R5
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);                                 // R6
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> done);                                // R8
endmodule

bind gfield_mac gfield_mac_chk #(.N(N), .D(D)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .result (result)
);

// File: tb/sim_gfield_mac.sv
module sim_gfield_mac;
    localparam int N = 83;
    localparam int D = 12;
    localparam int LAT = 9;   // posedges from issue negedge to the done negedge

    typedef struct {
        logic [N-1:0] exp;
        int           issue_cyc;
        string        tag;
    } exp_item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         op_sel = 1'b0;
    logic [N-1:0] opnd_a = '0, opnd_b = '0, opnd_c = '0, opnd_d = '0, poly = '0;
    logic         busy, done;
    logic [N-1:0] result;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    exp_item_t sb_q[$];

    always #2 clk = ~clk;   // 250 MHz
    always @(posedge clk) cyc <= cyc + 1;

    gfield_mac #(.N(N), .D(D)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_c(opnd_c), .opnd_d(opnd_d),
        .poly(poly), .busy(busy), .done(done), .result(result)
    );

    function automatic logic [N-1:0] rnd_el();
        logic [95:0] t;
        t = {$urandom, $urandom, $urandom};
        return t[N-1:0];
    endfunction

    // Bit-serial reference: scan multiplier from top bit, multiply by x, reduce.
    function automatic logic [N-1:0] ref_mac(input logic [N-1:0] a, input logic [N-1:0] b,
                                             input logic [N-1:0] c, input logic [N-1:0] p);
        logic [N-1:0] r;
        logic         top;
        r = '0;
        for (int i = N - 1; i >= 0; i--) begin
            top = r[N-1];
            r   = r << 1;
            if (top) r = r ^ p;
            if (b[i]) r = r ^ a;
        end
        return r ^ c;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [N-1:0] act,
                         input logic [N-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: issue one operation, push expectation, then scramble the inputs (R7).
    task automatic issue(input logic m, input logic [N-1:0] a, input logic [N-1:0] b,
                         input logic [N-1:0] c, input logic [N-1:0] d,
                         input logic [N-1:0] p, input string tag);
        exp_item_t it;
        while (busy) @(negedge clk);
        op_sel = m; opnd_a = a; opnd_b = b; opnd_c = c; opnd_d = d; poly = p;
        start  = 1'b1;
        it.exp       = m ? ref_mac(a, b ^ d, c, p) : ref_mac(a, b, c, p);
        it.issue_cyc = cyc;
        it.tag       = tag;
        sb_q.push_back(it);
        @(negedge clk);
        start  = 1'b0;
        op_sel = ~m;
        opnd_a = rnd_el(); opnd_b = rnd_el(); opnd_c = rnd_el();
        opnd_d = rnd_el(); poly = rnd_el();
    endtask

    // Monitor / scoreboard
    logic         prev_done = 1'b0;
    logic         hold_bad  = 1'b0;
    logic [N-1:0] last_res  = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_done)
                check(!done, "R4 done lasts one cycle", N'(done), '0);
            if (!done && result !== last_res)
                hold_bad = 1'b1;
            if (done) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R6 unexpected done", result, '0);
                end else begin
                    exp_item_t it;
                    it = sb_q.pop_front();
                    check(result === it.exp, it.tag, result, it.exp);
                    check((cyc - it.issue_cyc) == LAT, "R4 latency",
                          N'(cyc - it.issue_cyc), N'(LAT));
                    check(!hold_bad, "R8 result held between done pulses",
                          N'(hold_bad), '0);
                    check(busy, "R5 busy during done", N'(busy), 1);
                end
                hold_bad = 1'b0;
                last_res = result;
            end
            prev_done = done;
        end
    end

    logic [N-1:0] polys [0:3];

    initial begin
        polys[0] = 83'h95;                 // x^7+x^4+x^2+1
        polys[1] = 83'h1;
        polys[2] = rnd_el() | 83'h1;
        polys[3] = {N{1'b1}};

        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy === 1'b0, "R1 busy after reset", N'(busy), '0);
        check(done === 1'b0, "R1 done after reset", N'(done), '0);
        check(result === '0, "R1 result after reset", result, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0, "R5 idle busy low", N'(busy), '0);

        // Boundary operands
        issue(1'b0, '0, rnd_el(), rnd_el(), '0, polys[0], "R9 A=0");
        issue(1'b0, rnd_el(), '0, 83'h5a5, '0, polys[0], "R9 B=0 returns C");
        issue(1'b0, {N{1'b1}}, {N{1'b1}}, {N{1'b1}}, '0, polys[3], "R9 all ones");
        issue(1'b1, rnd_el(), 83'h1234, '0, 83'h1234, polys[0], "R3 B^D=0");
        issue(1'b0, 83'h1, rnd_el(), '0, '0, polys[1], "R2 A=1");

        // Random mode 0 / mode 1 across polynomials
        for (int k = 0; k < 24; k++)
            issue(1'b0, rnd_el(), rnd_el(), rnd_el(), rnd_el(), polys[k % 4],
                  "R2 mode0 random (R7, R9)");
        for (int k = 0; k < 24; k++)
            issue(1'b1, rnd_el(), rnd_el(), rnd_el(), rnd_el(), polys[k % 4],
                  "R3 mode1 random (R7, R9)");

        // R6: start held high through busy and the done cycle
        issue(1'b1, rnd_el(), rnd_el(), rnd_el(), rnd_el(), polys[0], "R6 base op");
        start = 1'b1;
        while (!done) begin
            opnd_a = rnd_el(); opnd_b = rnd_el();
            @(negedge clk);
        end
        start = 1'b0;
        @(negedge clk);
        check(busy === 1'b0, "R6 start ignored during busy/done", N'(busy), '0);
        repeat (12) @(negedge clk);
        check(busy === 1'b0, "R6 no extra operation", N'(busy), '0);

        // Back-to-back: new start in first idle cycle after done
        issue(1'b0, rnd_el(), rnd_el(), rnd_el(), '0, polys[2], "R2 back-to-back a");
        issue(1'b1, rnd_el(), rnd_el(), rnd_el(), rnd_el(), polys[2], "R3 back-to-back b");

        while (sb_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule